// File: doc/BRIEF.md
# Per-Channel Conversion Trigger Router

This block chooses, for each of eight converter input channels, which trigger starts that channel's sample-and-convert sequence. It then issues a start request to that channel. Each channel owns a 4-bit source code. The eight codes share one 32-bit configuration word, which is written and read over a minimal register port.

The candidate sources are:
- nothing;
- a one-shot software trigger, whose pending bit clears itself;
- a level software trigger, passed through as a level;
- a scan trigger, gated per channel by an include mask;
- a synchronous trigger input;
- eleven event lines, which are honoured only while event input is enabled.

Edge-type sources give a one-cycle request on their rising edge. Every start request leaves the block through a register.

Writes to the word are refused while the converter is enabled, and the refusal is reported as a bus error. A software-conversion mode silences every channel, whatever codes it holds.

Top module: `adc_trig_route`

## Requirements
- R1: Channel slot i (i = 0..7, serving analog input 8+i) takes its code from `cfg_wdata`/`cfg_rdata` bits [4i+3:4i]. After reset the word reads 0x00000019, so slot 0 holds code 1001 and slot 1 holds code 0001.
- R2: Code 0000 never produces a start request, whatever any trigger input does.
- R3: Code 0001: a pulse on `swtrig_set` sets a pending bit in the next cycle. The slot's `start_req` is 1 in exactly the following cycle, which is two cycles after the pulse. The pending bit then clears itself, so there is one request per pulse.
- R4: Code 0010: `start_req` follows `lvl_swtrig` with one cycle of delay and stays high for as long as the level is held.
- R5: Code 0011: a rising edge of `scan_trig` gives a one-cycle request in the next cycle, but only in slots whose `scan_mask` bit is 1.
- R6: Code 0100: a rising edge of `sync_trig` gives a one-cycle request in the next cycle. Holding the input high gives no further requests.
- R7: Codes 0101 to 1111 select event lines 0 to 10 in that order. A rising edge on the selected line gives a one-cycle request in the next cycle, but only while `evt_en` is 1. Otherwise the code behaves as 0000.
- R8: A write while `conv_en` is 1 leaves the word unchanged, and `cfg_err` is 1 in the cycle after the write. A write while `conv_en` is 0 stores the data and leaves `cfg_err` at 0.
- R9: While `swconv_en` is 1, no slot raises `start_req`, whatever its code.
- R10: `cfg_rdata` always shows the stored word, including while `conv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored configuration word |
| cfg_err | output | 1 | Error response, one cycle after a refused write |
| conv_en | input | 1 | Converter enabled; locks the word |
| swconv_en | input | 1 | Software-conversion mode; mutes all slots |
| evt_en | input | 1 | Event-line triggers allowed |
| swtrig_set | input | 1 | Sets the self-clearing software trigger bit |
| lvl_swtrig | input | 1 | Level software trigger |
| scan_trig | input | 1 | Scan trigger input |
| scan_mask | input | 8 | Per-slot scan include mask |
| sync_trig | input | 1 | Synchronous trigger input |
| evt_line | input | 11 | Event-system trigger lines, already synchronous |
| start_req | output | 8 | Per-slot start request |

## Verification
The bench builds the block with its default parameters: eight slots and eleven event lines. With these values the source code space is fully decoded, so both ends of the event range are reachable. Code 0101 maps to line 0 and code 1111 maps to line 10. Slot 0 has a reset code that points at an event line, and slot 1 has a reset code that selects the self-clearing software trigger. This lets the reset state be checked through behaviour as well as through readback. Each scenario reprograms the word so that several slots carry distinct codes at once. A wrong field offset or a wrong decode therefore shows up as a wrong request bit pattern.

// File: rtl/adc_trig_pkg.sv
// Package: shared source codes and geometry for the trigger router.
// Assumes the 4-bit code space is fixed; event codes start at EVT_BASE.
package adc_trig_pkg;

    localparam int SEL_W    = 4;
    localparam int EVT_BASE = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 4'd0,
        SRC_SWP  = 4'd1,
        SRC_SWL  = 4'd2,
        SRC_SCAN = 4'd3,
        SRC_SYNC = 4'd4
    } src_code_e;

endpackage

// File: rtl/trig_cfg_reg.sv
// Module: configuration word holding one source code per slot.
// Does: stores the word on accepted writes, refuses writes while the
// converter is enabled and reports an error one cycle later.
// Assumes: single register, no address decode; reads are always live.
module trig_cfg_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         lock,
    output logic [W-1:0] cfg_q,
    output logic         err_q
);

    // Hold the word; update only on unlocked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (wr && !lock) begin
            cfg_q <= wdata;
        end
    end

    // Registered error response for refused writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= wr && lock;
        end
    end

    // R8: locked write leaves the word unchanged and flags an error
    a_r8_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lock) |=> (err_q && cfg_q == $past(cfg_q)));

    // R8: unlocked write lands and raises no error
    a_r8_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !lock) |=> (!err_q && cfg_q == $past(wdata)));

    // R8: no write means no error and no change
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (!err_q && $stable(cfg_q)));

endmodule

// File: rtl/trig_src_cond.sv
// Module: conditions the shared trigger sources.
// Does: keeps the self-clearing software trigger bit and turns the scan,
// synchronous and event inputs into one-cycle rising-edge pulses.
// Assumes: every input is already synchronous to clk.
module trig_src_cond #(
    parameter int N_EVT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_set,
    input  logic             scan_in,
    input  logic             sync_in,
    input  logic [N_EVT-1:0] evt_in,
    output logic             sw_pend,
    output logic             scan_rise,
    output logic             sync_rise,
    output logic [N_EVT-1:0] evt_rise
);

    logic             scan_d;
    logic             sync_d;
    logic [N_EVT-1:0] evt_d;

    // Software bit: set by a pulse, cleared once it has been issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend <= 1'b0;
        end else begin
            sw_pend <= sw_set;
        end
    end

    // Previous-cycle copies of the scan and synchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_d <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            scan_d <= scan_in;
            sync_d <= sync_in;
        end
    end

    // Rising-edge pulses for the scan and synchronous inputs.
    always_comb begin
        scan_rise = scan_in && !scan_d;
        sync_rise = sync_in && !sync_d;
    end

    // One edge detector per event line.
    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_d[e] <= 1'b0;
            end else begin
                evt_d[e] <= evt_in[e];
            end
        end
        assign evt_rise[e] = evt_in[e] && !evt_d[e];
    end

    // R3: pending bit clears itself unless set again
    a_r3_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && !sw_set) |=> !sw_pend);

    // R6: edge pulse never lasts two cycles
    a_r6_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> !sync_rise);

endmodule

// File: rtl/trig_chan_sel.sv
// Module: per-slot source selector.
// Does: decodes one 4-bit code against the conditioned sources and
// registers the slot's start request.
// Assumes: the sources are single-cycle pulses except the level trigger.
module trig_chan_sel
    import adc_trig_pkg::*;
#(
    parameter int N_EVT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             mute,
    input  logic             evt_en,
    input  logic             scan_inc,
    input  logic             sw_pend,
    input  logic             lvl_sw,
    input  logic             scan_rise,
    input  logic             sync_rise,
    input  logic [N_EVT-1:0] evt_rise,
    output logic             start_q
);

    logic [SEL_W-1:0] evt_idx;
    logic             evt_hit;
    logic             hit;

    // Event line chosen by codes at and above EVT_BASE.
    always_comb begin
        evt_idx = sel - SEL_W'(EVT_BASE);
        evt_hit = 1'b0;
        for (int e = 0; e < N_EVT; e++) begin
            if (int'(evt_idx) == e) begin
                evt_hit = evt_rise[e];
            end
        end
    end

    // Decode the slot's code into a trigger hit.
    always_comb begin
        case (sel)
            SRC_NONE: hit = 1'b0;
            SRC_SWP:  hit = sw_pend;
            SRC_SWL:  hit = lvl_sw;
            SRC_SCAN: hit = scan_rise && scan_inc;
            SRC_SYNC: hit = sync_rise;
            default:  hit = evt_en && evt_hit;
        endcase
    end

    // Registered start request, silenced in software-conversion mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= hit && !mute;
        end
    end

    // R9: muted slot stays quiet
    a_r9_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> !start_q);

    // R2: code zero never triggers
    a_r2_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_NONE) |=> !start_q);

    // R7: event codes are dead while event input is disabled
    a_r7_evt_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_en && sel >= SEL_W'(EVT_BASE)) |=> !start_q);

    // R5: excluded slot ignores scan trigger
    a_r5_scan_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_SCAN && !scan_inc) |=> !start_q);

endmodule

// File: rtl/adc_trig_route.sv
// Module: top of the per-slot conversion trigger router.
// Does: joins the configuration word, the shared source conditioning and
// one selector per slot.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module adc_trig_route
    import adc_trig_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int N_EVT = 11,
    parameter logic [N_CH*SEL_W-1:0] CFG_RST = (N_CH*SEL_W)'(32'h0000_0019)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [N_CH*SEL_W-1:0] cfg_wdata,
    output logic [N_CH*SEL_W-1:0] cfg_rdata,
    output logic                  cfg_err,
    input  logic                  conv_en,
    input  logic                  swconv_en,
    input  logic                  evt_en,
    input  logic                  swtrig_set,
    input  logic                  lvl_swtrig,
    input  logic                  scan_trig,
    input  logic [N_CH-1:0]       scan_mask,
    input  logic                  sync_trig,
    input  logic [N_EVT-1:0]      evt_line,
    output logic [N_CH-1:0]       start_req
);

    localparam int CFG_W = N_CH * SEL_W;

    logic [CFG_W-1:0] cfg_q;
    logic             sw_pend;
    logic             scan_rise;
    logic             sync_rise;
    logic [N_EVT-1:0] evt_rise;

    trig_cfg_reg #(
        .W       (CFG_W),
        .RST_VAL (CFG_RST)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .lock  (conv_en),
        .cfg_q (cfg_q),
        .err_q (cfg_err)
    );

    assign cfg_rdata = cfg_q;

    trig_src_cond #(
        .N_EVT (N_EVT)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_set    (swtrig_set),
        .scan_in   (scan_trig),
        .sync_in   (sync_trig),
        .evt_in    (evt_line),
        .sw_pend   (sw_pend),
        .scan_rise (scan_rise),
        .sync_rise (sync_rise),
        .evt_rise  (evt_rise)
    );

    // One selector per slot, each reading its own 4-bit field.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        trig_chan_sel #(
            .N_EVT (N_EVT)
        ) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (cfg_q[c*SEL_W +: SEL_W]),
            .mute      (swconv_en),
            .evt_en    (evt_en),
            .scan_inc  (scan_mask[c]),
            .sw_pend   (sw_pend),
            .lvl_sw    (lvl_swtrig),
            .scan_rise (scan_rise),
            .sync_rise (sync_rise),
            .evt_rise  (evt_rise),
            .start_q   (start_req[c])
        );
    end

    // R10: readback equals the word last accepted
    a_r10_read_live: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !conv_en) |=> cfg_rdata == $past(cfg_wdata));

    // R4: held level keeps level-coded slots requesting
    a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_swtrig && !swconv_en && cfg_q[SEL_W-1:0] == SRC_SWL) |=> start_req[0]);

endmodule

// File: tb/adc_trig_route_tb.sv
// Directed bench for the trigger router; each task checks its own results.
module adc_trig_route_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        conv_en = 1'b0;
    logic        swconv_en = 1'b0;
    logic        evt_en = 1'b0;
    logic        swtrig_set = 1'b0;
    logic        lvl_swtrig = 1'b0;
    logic        scan_trig = 1'b0;
    logic [7:0]  scan_mask = '0;
    logic        sync_trig = 1'b0;
    logic [10:0] evt_line = '0;
    logic [7:0]  start_req;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    adc_trig_route dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .conv_en    (conv_en),
        .swconv_en  (swconv_en),
        .evt_en     (evt_en),
        .swtrig_set (swtrig_set),
        .lvl_swtrig (lvl_swtrig),
        .scan_trig  (scan_trig),
        .scan_mask  (scan_mask),
        .sync_trig  (sync_trig),
        .evt_line   (evt_line),
        .start_req  (start_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] d);
        step();
        cfg_wr = 1'b1;
        cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", cfg_rdata, 32'h0000_0019);
        chk("R1 reset start", {24'h0, start_req}, 32'h0);
        chk("R8 reset err", {31'h0, cfg_err}, 32'h0);
    endtask

    task automatic t_swp();
        // reset codes: slot1 = software one-shot, slot0 = event line 4
        step();
        swtrig_set = 1'b1;
        step();
        swtrig_set = 1'b0;
        chk("R3 no early request", {24'h0, start_req}, 32'h0);
        step();
        chk("R3 one-shot request", {24'h0, start_req}, 32'h2);
        step();
        chk("R3 self-cleared", {24'h0, start_req}, 32'h0);
        // slot0 event line 4 via reset code 1001
        evt_en = 1'b1;
        evt_line = 11'h010;
        step();
        chk("R1 reset slot0 event4", {24'h0, start_req}, 32'h1);
        evt_line = '0;
        evt_en = 1'b0;
        step();
    endtask

    task automatic t_lock();
        conv_en = 1'b1;
        write_cfg(32'hDEAD_BEEF);
        chk("R8 locked err", {31'h0, cfg_err}, 32'h1);
        chk("R10 read while locked", cfg_rdata, 32'h0000_0019);
        step();
        chk("R8 err one cycle", {31'h0, cfg_err}, 32'h0);
        conv_en = 1'b0;
        write_cfg(32'h1234_5670);
        chk("R8 open write no err", {31'h0, cfg_err}, 32'h0);
        chk("R10 readback", cfg_rdata, 32'h1234_5670);
    endtask

    task automatic t_level();
        write_cfg(32'h0000_2200);
        lvl_swtrig = 1'b1;
        step();
        chk("R4 level start", {24'h0, start_req}, 32'h0C);
        step();
        step();
        chk("R4 level held", {24'h0, start_req}, 32'h0C);
        lvl_swtrig = 1'b0;
        step();
        chk("R4 level released", {24'h0, start_req}, 32'h0);
    endtask

    task automatic t_scan();
        write_cfg(32'h3333_3333);
        scan_mask = 8'hA5;
        scan_trig = 1'b1;
        step();
        chk("R5 masked scan", {24'h0, start_req}, 32'hA5);
        step();
        chk("R5 scan single", {24'h0, start_req}, 32'h0);
        scan_trig = 1'b0;
        scan_mask = 8'h00;
        step();
    endtask

    task automatic t_sync();
        write_cfg(32'h4400_0004);
        sync_trig = 1'b1;
        step();
        chk("R6 sync edge", {24'h0, start_req}, 32'hC1);
        step();
        chk("R6 sync held no repeat", {24'h0, start_req}, 32'h0);
        sync_trig = 1'b0;
        step();
    endtask

    task automatic t_evt();
        // slot0 code 0101 (line0), slot1 code 1111 (line10), slot2 code 1010 (line5)
        write_cfg(32'h0000_0AF5);
        evt_en = 1'b1;
        evt_line = 11'h400;
        step();
        chk("R7 line10 top code", {24'h0, start_req}, 32'h2);
        evt_line = 11'h021;
        step();
        chk("R7 line0 and line5", {24'h0, start_req}, 32'h5);
        evt_line = '0;
        evt_en = 1'b0;
        step();
        evt_line = 11'h421;
        step();
        chk("R7 events gated off", {24'h0, start_req}, 32'h0);
        evt_line = '0;
        step();
    endtask

    task automatic t_none();
        write_cfg(32'h0000_0000);
        evt_en = 1'b1;
        lvl_swtrig = 1'b1;
        scan_mask = 8'hFF;
        scan_trig = 1'b1;
        sync_trig = 1'b1;
        evt_line = 11'h7FF;
        swtrig_set = 1'b1;
        step();
        swtrig_set = 1'b0;
        step();
        chk("R2 code zero ignores all", {24'h0, start_req}, 32'h0);
        lvl_swtrig = 1'b0;
        scan_trig = 1'b0;
        sync_trig = 1'b0;
        evt_line = '0;
        evt_en = 1'b0;
        scan_mask = '0;
        step();
    endtask

    task automatic t_swconv();
        write_cfg(32'h2222_2222);
        swconv_en = 1'b1;
        lvl_swtrig = 1'b1;
        step();
        step();
        chk("R9 software mode mutes", {24'h0, start_req}, 32'h0);
        swconv_en = 1'b0;
        step();
        chk("R9 unmuted resumes", {24'h0, start_req}, 32'hFF);
        lvl_swtrig = 1'b0;
        step();
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_swp();
        t_lock();
        t_level();
        t_scan();
        t_sync();
        t_evt();
        t_none();
        t_swconv();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule